// File: doc/BRIEF.md
# Line-Frequency Tick Timer

This block produces a periodic interrupt at mains rate, 50 or 60 ticks per second. The tick is made by dividing the system clock in a prescaler. Software sees a single 16-bit control word with two live bits: a ready flag, set by every tick, and an interrupt-enable flag. Accesses arrive as single-cycle requests, and each request gets a registered response one cycle later. Any access can be answered with a bus error. The interrupt request is a level output. The interrupt controller pulses `irq_ack` when it takes the interrupt.

A static parameter `VARIANT` selects one of four historical behaviours:
- `VAR_NOREG`: no register at all. Every access errors, and interrupts are always enabled.
- `VAR_PLAIN`: the register exists but the ready flag cannot be read.
- `VAR_MONITOR`: the ready flag can be read and can be cleared by software.
- `VAR_ACKCLR`: as `VAR_MONITOR`, and an interrupt acknowledge also clears the ready flag.

Two small state machines make up the block:
- The prescaler has the states `TK_COUNT` and `TK_FIRE`.
  - `TK_COUNT` moves to `TK_FIRE` when its down-counter reaches zero.
  - `TK_FIRE` is one cycle long. It asserts the internal tick, reloads the counter for the current rate and returns to `TK_COUNT`.
- The bus port has the states `BP_IDLE` and `BP_RESP`.
  - Either state moves to `BP_RESP` when a request is present and to `BP_IDLE` when none is.
  - The response is valid exactly in `BP_RESP`.

Top module: `mains_tick_timer`

## Requirements
- R1: After reset, including a reset in mid-run, the ready flag is 1, the enable flag is 0 and `irq` is 0. The rate returns to `DEFAULT_HZ` and the prescaler restarts from the start of a period.
- R2: With period P = `SYS_CLK_HZ`/rate, the ready flag is first set, and `irq` first rises when it is enabled or forced, at the P-th rising clock edge after reset is released. Later ticks follow every P edges.
- R3: Each tick sets the ready flag. It raises `irq` if the enable flag is 1, or always in `VAR_NOREG`.
- R4: A `rate_set` pulse with `rate_hz` equal to 50 or 60 selects that rate, starting with the period after the current one. Any other value is ignored.
- R5: In `VAR_NOREG`, every response has `rsp_err`=1 and `rsp_rdata`=0, and writes change nothing. In the other variants, `rsp_err` is always 0.
- R6: A read returns the enable flag in bit 6. In `VAR_MONITOR` and `VAR_ACKCLR` it also returns the ready flag in bit 7. All other bits read 0, and bit 7 reads 0 in `VAR_PLAIN`. A write's response data is 0.
- R7: A write loads the enable flag from bit 6. In the monitor variants, writing 0 in bit 7 clears the ready flag and writing 1 leaves it unchanged. In `VAR_PLAIN`, bit 7 is ignored.
- R8: A write with `bus_odd`=1 (odd byte) changes nothing.
- R9: After a write, `irq` is dropped unless the ready flag is 1 and the enable flag is 1 (or forced). A write never raises `irq`.
- R10: `irq_ack` drops `irq`. In `VAR_ACKCLR` it also clears the ready flag.
- R11: When a tick lands in the same cycle as a write or an acknowledge, the write and acknowledge apply first. The tick then sets the ready flag and raises `irq` based on the enable flag as just written.
- R12: Every cycle with `bus_req`=1 is followed, in the next cycle, by `rsp_vld`=1 carrying that request's result. `rsp_vld` is 0 after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | Access targets the odd (upper) byte |
| bus_wdata | input | DATA_W | Write data; bit 7 ready, bit 6 enable |
| rsp_vld | output | 1 | Response valid, one cycle after request |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| rate_set | input | 1 | Rate change strobe |
| rate_hz | input | 7 | Requested rate in ticks per second |

## Verification
The properties take for granted that `VARIANT` is fixed for the life of the part. They also take for granted that a property about a tick raising `irq` is not judged in a cycle where a write changes the enable flag. The stimulus drives every input just after a falling edge and holds it for one whole cycle. All four variants share one input stream, so each access, acknowledge and rate change exercises every variant at once. Acknowledges are aimed at real interrupts, and one write-plus-acknowledge is placed on the exact tick cycle to reach the collision case.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    typedef enum logic [1:0] {
        VAR_NOREG   = 2'd0,
        VAR_PLAIN   = 2'd1,
        VAR_MONITOR = 2'd2,
        VAR_ACKCLR  = 2'd3
    } mtt_variant_e;

    typedef enum logic {
        TK_COUNT = 1'b0,
        TK_FIRE  = 1'b1
    } tick_state_e;

    typedef enum logic {
        BP_IDLE = 1'b0,
        BP_RESP = 1'b1
    } port_state_e;

    localparam int READY_BIT  = 7;
    localparam int ENABLE_BIT = 6;
    localparam int RATE_W     = 7;
    localparam int RATE_LOW   = 50;
    localparam int RATE_HIGH  = 60;

    function automatic int unsigned period_cycles(int unsigned sys_hz, int unsigned rate);
        return sys_hz / rate;
    endfunction

    function automatic bit has_register(mtt_variant_e v);
        return v != VAR_NOREG;
    endfunction

    function automatic bit has_monitor(mtt_variant_e v);
        return (v == VAR_MONITOR) || (v == VAR_ACKCLR);
    endfunction

endpackage

// File: rtl/mtt_prescaler.sv
module mtt_prescaler
    import mtt_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 100_000_000,
    parameter int unsigned DEFAULT_HZ = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_set,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              tick
);
    localparam int unsigned P_LOW  = period_cycles(SYS_CLK_HZ, RATE_LOW);
    localparam int unsigned P_HIGH = period_cycles(SYS_CLK_HZ, RATE_HIGH);
    localparam int CNT_W = $clog2(P_LOW) + 1;
    localparam logic [CNT_W-1:0] LOAD_LOW  = CNT_W'(P_LOW - 2);
    localparam logic [CNT_W-1:0] LOAD_HIGH = CNT_W'(P_HIGH - 2);
    localparam bit DEFAULT_LOW = (DEFAULT_HZ == RATE_LOW);
    localparam logic [CNT_W-1:0] LOAD_RESET = DEFAULT_LOW ? LOAD_LOW : LOAD_HIGH;

    tick_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             use_low_q;

    // Rate selection: only the two legal rates are taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_low_q <= DEFAULT_LOW;
        end else if (rate_set) begin
            if (rate_hz == RATE_W'(RATE_LOW)) begin
                use_low_q <= 1'b1;
            end else if (rate_hz == RATE_W'(RATE_HIGH)) begin
                use_low_q <= 1'b0;
            end
        end
    end

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TK_COUNT: begin
                if (cnt_q == '0) begin
                    state_d = TK_FIRE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            TK_FIRE: begin
                cnt_d   = use_low_q ? LOAD_LOW : LOAD_HIGH;
                state_d = TK_COUNT;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TK_COUNT;
            cnt_q   <= LOAD_RESET;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        tick = (state_q == TK_FIRE);
    end

endmodule

// File: rtl/mtt_csr.sv
module mtt_csr
    import mtt_pkg::*;
#(
    parameter mtt_variant_e VARIANT = VAR_MONITOR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wr_stb,
    input  logic wr_ready,
    input  logic wr_enable,
    input  logic irq_ack,
    output logic ready_q,
    output logic enable_q,
    output logic irq_q
);
    localparam bit FORCE_EN = !has_register(VARIANT);
    localparam bit MON      = has_monitor(VARIANT);
    localparam bit ACK_CLR  = (VARIANT == VAR_ACKCLR);

    logic ready_d, enable_d, irq_d;

    // Ordered update: write, then acknowledge, then tick.
    always_comb begin
        ready_d  = ready_q;
        enable_d = enable_q;
        irq_d    = irq_q;
        if (wr_stb) begin
            enable_d = wr_enable;
            if (MON && !wr_ready) begin
                ready_d = 1'b0;
            end
            if (!ready_d || !(enable_d || FORCE_EN)) begin
                irq_d = 1'b0;
            end
        end
        if (irq_ack) begin
            irq_d = 1'b0;
            if (ACK_CLR) begin
                ready_d = 1'b0;
            end
        end
        if (tick) begin
            ready_d = 1'b1;
            if (enable_d || FORCE_EN) begin
                irq_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q  <= 1'b1;
            enable_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            ready_q  <= ready_d;
            enable_q <= enable_d;
            irq_q    <= irq_d;
        end
    end

endmodule

// File: rtl/mtt_busport.sv
module mtt_busport
    import mtt_pkg::*;
#(
    parameter mtt_variant_e VARIANT = VAR_MONITOR,
    parameter int           DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_odd,
    input  logic              ready_q,
    input  logic              enable_q,
    output logic              wr_stb,
    output logic              rsp_vld,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam bit REG = has_register(VARIANT);
    localparam bit MON = has_monitor(VARIANT);

    port_state_e       state_q, state_d;
    logic [DATA_W-1:0] read_word;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    always_comb begin
        read_word             = '0;
        read_word[ENABLE_BIT] = enable_q;
        if (MON) begin
            read_word[READY_BIT] = ready_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_IDLE: if (bus_req)  state_d = BP_RESP;
            BP_RESP: if (!bus_req) state_d = BP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BP_IDLE;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_req) begin
                err_q   <= !REG;
                rdata_q <= (REG && !bus_we) ? read_word : '0;
            end
        end
    end

    always_comb begin
        wr_stb    = bus_req && bus_we && !bus_odd && REG;
        rsp_vld   = (state_q == BP_RESP);
        rsp_err   = err_q;
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/mains_tick_timer.sv
module mains_tick_timer
    import mtt_pkg::*;
#(
    parameter mtt_variant_e VARIANT    = VAR_MONITOR,
    parameter int unsigned  SYS_CLK_HZ = 100_000_000,
    parameter int unsigned  DEFAULT_HZ = 60,
    parameter int           DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_odd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_vld,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq,
    input  logic              irq_ack,
    input  logic              rate_set,
    input  logic [6:0]        rate_hz
);
    logic tick;
    logic wr_stb;
    logic ready_q;
    logic enable_q;
    logic unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:READY_BIT+1], bus_wdata[ENABLE_BIT-1:0]};

    mtt_prescaler #(
        .SYS_CLK_HZ (SYS_CLK_HZ),
        .DEFAULT_HZ (DEFAULT_HZ)
    ) u_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_set (rate_set),
        .rate_hz  (rate_hz),
        .tick     (tick)
    );

    mtt_busport #(
        .VARIANT (VARIANT),
        .DATA_W  (DATA_W)
    ) u_busport (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_odd   (bus_odd),
        .ready_q   (ready_q),
        .enable_q  (enable_q),
        .wr_stb    (wr_stb),
        .rsp_vld   (rsp_vld),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    mtt_csr #(
        .VARIANT (VARIANT)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_stb    (wr_stb),
        .wr_ready  (bus_wdata[READY_BIT]),
        .wr_enable (bus_wdata[ENABLE_BIT]),
        .irq_ack   (irq_ack),
        .ready_q   (ready_q),
        .enable_q  (enable_q),
        .irq_q     (irq)
    );

endmodule

// File: rtl/mains_tick_timer_chk.sv
module mains_tick_timer_chk
    import mtt_pkg::*;
#(
    parameter mtt_variant_e VARIANT = VAR_MONITOR,
    parameter int           DATA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_odd,
    input logic              rsp_vld,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq,
    input logic              irq_ack,
    input logic              tick,
    input logic              ready_q,
    input logic              enable_q
);
    localparam bit FORCE_EN = !has_register(VARIANT);
    localparam bit MON      = has_monitor(VARIANT);

    p_irq_implies_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready_q);

    p_tick_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(bus_req && bus_we) && (enable_q || FORCE_EN)) |=> irq);

    p_error_by_variant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_err == FORCE_EN));

    p_read_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_rdata[DATA_W-1:8] == '0 && rsp_rdata[5:0] == '0));

    p_hidden_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !MON) |-> !rsp_rdata[READY_BIT]);

    p_odd_write_keeps_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_odd) |=> $stable(enable_q));

    p_write_never_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !tick && !irq) |=> !irq);

    p_ack_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !tick) |=> !irq);

    p_rsp_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> rsp_vld);

    p_no_rsp_without_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !rsp_vld);

endmodule

bind mains_tick_timer mains_tick_timer_chk #(
    .VARIANT (VARIANT),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_odd   (bus_odd),
    .rsp_vld   (rsp_vld),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .tick      (tick),
    .ready_q   (ready_q),
    .enable_q  (enable_q)
);

// File: tb/mains_tick_timer_bench.sv
module mains_tick_timer_bench;
    import mtt_pkg::*;

    localparam int SYS_HZ = 3000;
    localparam int NV     = 4;
    localparam int DW     = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0, bus_odd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          irq_ack = 1'b0, rate_set = 1'b0;
    logic [6:0]    rate_hz = '0;

    logic [NV-1:0] irq_w, vld_w, err_w;
    logic [DW-1:0] rdata_w [NV];

    for (genvar gv = 0; gv < NV; gv++) begin : g_var
        mains_tick_timer #(
            .VARIANT    (mtt_variant_e'(gv)),
            .SYS_CLK_HZ (SYS_HZ),
            .DEFAULT_HZ (60),
            .DATA_W     (DW)
        ) u_mains_tick_timer (
            .clk (clk), .rst_n (rst_n),
            .bus_req (bus_req), .bus_we (bus_we), .bus_odd (bus_odd), .bus_wdata (bus_wdata),
            .rsp_vld (vld_w[gv]), .rsp_err (err_w[gv]), .rsp_rdata (rdata_w[gv]),
            .irq (irq_w[gv]), .irq_ack (irq_ack),
            .rate_set (rate_set), .rate_hz (rate_hz)
        );
    end

    // Behavioural reference model.
    int            m_cnt, m_period, m_rate;
    bit            m_ready [NV], m_en [NV], m_irq [NV], m_vld [NV], m_err [NV];
    logic [DW-1:0] m_rdata [NV];

    always @(posedge clk) begin : model
        bit tk;
        if (!rst_n) begin
            m_cnt = 0; m_rate = 60; m_period = SYS_HZ / 60;
            for (int v = 0; v < NV; v++) begin
                m_ready[v] = 1; m_en[v] = 0; m_irq[v] = 0;
                m_vld[v] = 0; m_err[v] = 0; m_rdata[v] = '0;
            end
        end else begin
            tk = (m_cnt == m_period - 1);
            if (tk) begin m_cnt = 0; m_period = SYS_HZ / m_rate; end
            else m_cnt++;
            if (rate_set && (rate_hz == 50 || rate_hz == 60)) m_rate = int'(rate_hz);
            for (int v = 0; v < NV; v++) begin
                m_vld[v] = bus_req;
                if (bus_req) begin
                    m_err[v] = (v == 0);
                    m_rdata[v] = '0;
                    if (v != 0 && !bus_we) begin
                        m_rdata[v][6] = m_en[v];
                        if (v >= 2) m_rdata[v][7] = m_ready[v];
                    end
                end
                if (bus_req && bus_we && !bus_odd && v != 0) begin
                    m_en[v] = bus_wdata[6];
                    if (v >= 2 && !bus_wdata[7]) m_ready[v] = 0;
                    if (!m_ready[v] || !m_en[v]) m_irq[v] = 0;
                end
                if (irq_ack) begin
                    m_irq[v] = 0;
                    if (v == 3) m_ready[v] = 0;
                end
                if (tk) begin
                    m_ready[v] = 1;
                    if (m_en[v] || v == 0) m_irq[v] = 1;
                end
            end
        end
    end

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    task automatic chk(bit ok, string what, int v, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s variant %0d %s act=%0h exp=%0h", cur_req, v, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            for (int v = 0; v < NV; v++) begin
                chk(irq_w[v] == m_irq[v], "irq", v, int'(irq_w[v]), int'(m_irq[v]));
                chk(vld_w[v] == m_vld[v], "rsp_vld", v, int'(vld_w[v]), int'(m_vld[v]));
                if (m_vld[v]) begin
                    chk(err_w[v] == m_err[v], "rsp_err", v, int'(err_w[v]), int'(m_err[v]));
                    chk(rdata_w[v] == m_rdata[v], "rsp_rdata", v, int'(rdata_w[v]), int'(m_rdata[v]));
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic access(bit we, bit odd, logic [DW-1:0] d, bit ack);
        bus_req = 1; bus_we = we; bus_odd = odd; bus_wdata = d; irq_ack = ack;
        step();
        bus_req = 0; bus_we = 0; bus_odd = 0; bus_wdata = '0; irq_ack = 0;
    endtask

    task automatic run_acking(int n);
        for (int i = 0; i < n; i++) begin
            irq_ack = irq_w[1];
            step();
        end
        irq_ack = 0;
    endtask

    task automatic wait_tick_edge();
        int guard = 0;
        while (m_cnt != m_period - 1 && guard < 200) begin step(); guard++; end
    endtask

    task automatic first_tick_count(int expected);
        int k = 0;
        while (!irq_w[0] && k < 300) begin step(); k++; end
        chk(k == expected, "cycles to first tick", 0, k, expected);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, read back right after release
        cur_req = "R1";
        chk(irq_w == '0, "irq after reset", 0, int'(irq_w), 0);
        access(0, 0, '0, 0);
        // R2: first tick at edge P=50 (one edge used by the read)
        cur_req = "R2";
        first_tick_count(49);
        cur_req = "R3";
        idle(10);
        cur_req = "R6";
        access(0, 0, '0, 0);
        // R9: enable with ready kept; a write must not raise irq
        cur_req = "R9";
        access(1, 0, 16'h00C0, 0);
        idle(3);
        cur_req = "R3";
        idle(55);
        cur_req = "R6";
        access(0, 0, '0, 0);
        // R10: acknowledge drops irq, clears ready in the acknowledge-clear variant
        cur_req = "R10";
        access(0, 0, '0, 1);
        access(0, 0, '0, 0);
        cur_req = "R3";
        idle(55);
        // R7: bit 7 = 0 clears ready in monitor variants
        cur_req = "R7";
        access(1, 0, 16'h0040, 0);
        access(0, 0, '0, 0);
        access(1, 0, 16'h00C0, 0);
        access(0, 0, '0, 0);
        // R8: odd-byte write ignored
        cur_req = "R8";
        access(1, 1, 16'h0000, 0);
        access(0, 0, '0, 0);
        idle(50);
        // R9: clearing enable drops a pending irq
        cur_req = "R9";
        access(1, 0, 16'h0080, 0);
        access(0, 0, '0, 0);
        // R4: rate changes, legal and illegal
        cur_req = "R4";
        access(1, 0, 16'h00C0, 0);
        rate_set = 1; rate_hz = 7'd50; step(); rate_set = 0;
        run_acking(140);
        rate_set = 1; rate_hz = 7'd55; step(); rate_set = 0;
        run_acking(140);
        rate_set = 1; rate_hz = 7'd60; step(); rate_set = 0;
        run_acking(130);
        // R11: write and acknowledge on the tick edge
        cur_req = "R11";
        wait_tick_edge();
        access(1, 0, 16'h0000, 1);
        access(0, 0, '0, 0);
        wait_tick_edge();
        access(1, 0, 16'h0040, 1);
        access(0, 0, '0, 0);
        // R5: no-register variant keeps erroring
        cur_req = "R5";
        access(1, 0, 16'h0000, 0);
        access(0, 0, '0, 0);
        // R12: back-to-back requests
        cur_req = "R12";
        bus_req = 1; step(); step(); bus_req = 0;
        step();
        // R1: reset in mid-run
        cur_req = "R1";
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        access(0, 0, '0, 0);
        cur_req = "R2";
        first_tick_count(49);
        idle(5);
        finish_run();
    end

endmodule